// File: doc/BRIEF.md
# Dual-mode SPI clock divider

This block derives the serial clock of an SPI master from the bus clock. One 8-bit divide field sets the rate under one of two laws picked by a mode bit. The power-of-two law halves the rate once per step of the field. The linear law divides by an even count that grows by two per step. Next to the clock level the block emits two single-cycle strobes, one on each clock edge. A neighbouring shift engine uses one strobe to launch the next bit and the other to capture the incoming bit.

Clock polarity and phase are latched while the block is disabled and held while it is enabled. A run request starts the clock from its idle level. Once started, the clock always completes whole periods. Dropping the enable stops everything at once and parks the clock at its idle level.

Top module: `spi_sclk_divider`

## Requirements
- R1: With `lin_mode`=0 and `div_val`=N, where N is 0 to 15, each half-period of `sclk` lasts 2^N bus cycles, so the full period is 2^(N+1) cycles.
- R2: With `lin_mode`=0, any `div_val` above 15 acts as 15, giving a half-period of 32768 cycles.
- R3: With `lin_mode`=1 and `div_val`=N, where N is 0 to 255, each half-period lasts N+1 bus cycles. N=0 gives half the bus clock rate, which is the fastest setting.
- R4: While the block is idle, `sclk` equals the latched polarity. After a rising clock edge samples `run` high, the first `sclk` edge comes one full half-period later.
- R5: With the latched phase at 0, `sample_stb` pulses with the leading edge and `shift_stb` pulses with the trailing edge. With the latched phase at 1, the roles swap. Each strobe is high for exactly the one cycle in which `sclk` first shows its new level.
- R6: `cpol` and `cpha` are latched only while `en` is low. Changes made while `en` is high affect neither `sclk` nor the strobes.
- R7: When a clock edge samples `en` low, after that edge `sclk` equals `cpol`, both strobes are low, and the divider count is cleared. After re-enabling, the first edge again waits a full half-period.
- R8: `run` is examined at each trailing edge. If `run` is low at that point, the clock stops at its idle level and produces no further edges until a new request arrives.
- R9: The two strobes are never high together. While `en` stays high, `sclk` changes only in a cycle in which one of the strobes is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Block enable; while low, polarity and phase are latched |
| lin_mode | input | 1 | 0: power-of-two law, 1: linear law |
| div_val | input | DIV_W | Divide value N |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0: sample on the leading edge, 1: sample on the trailing edge |
| run | input | 1 | Request to generate clock periods |
| sclk | output | 1 | Serial clock level |
| shift_stb | output | 1 | One-cycle strobe on the launch edge |
| sample_stb | output | 1 | One-cycle strobe on the capture edge |

## Verification
The bench builds the block with its default parameters: an 8-bit divide field and a power-of-two exponent ceiling of 15. These defaults bring the full clamp within reach. The bench measures a 32768-cycle half-period for N=15 and for N=20, so the saturation point of the power-of-two law is checked directly. The default width also covers both ends of the linear law, N=0 and N=255. Edge timings are measured in bus cycles from the cycle in which the request is sampled.

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider #(
  parameter int DIV_W   = 8,
  parameter int POW_MAX = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             lin_mode,
  input  logic [DIV_W-1:0] div_val,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             run,
  output logic             sclk,
  output logic             shift_stb,
  output logic             sample_stb
);

  localparam int EXP_W = $clog2(POW_MAX + 1);
  localparam int HW    = (POW_MAX + 1 > DIV_W + 1) ? POW_MAX + 1 : DIV_W + 1;

  logic          pol_q, pha_q, active_q, phase_q, shift_q, sample_q;
  logic [HW-1:0] cnt_q, half_w;
  logic [EXP_W-1:0] exp_w;
  logic          tick;

  // power-of-two exponent saturates at POW_MAX
  assign exp_w  = (32'(div_val) > POW_MAX) ? EXP_W'(POW_MAX) : EXP_W'(div_val);
  assign half_w = lin_mode ? (HW'(div_val) + HW'(1)) : (HW'(1) << exp_w);
  assign tick   = active_q && (cnt_q >= half_w - HW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_q    <= 1'b0;
      pha_q    <= 1'b0;
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      cnt_q    <= '0;
      shift_q  <= 1'b0;
      sample_q <= 1'b0;
    end else if (!en) begin
      pol_q    <= cpol;
      pha_q    <= cpha;
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      cnt_q    <= '0;
      shift_q  <= 1'b0;
      sample_q <= 1'b0;
    end else begin
      shift_q  <= tick && (phase_q != pha_q);
      sample_q <= tick && (phase_q == pha_q);
      if (!active_q) begin
        active_q <= run;
        cnt_q    <= '0;
      end else if (tick) begin
        cnt_q   <= '0;
        phase_q <= ~phase_q;
        if (phase_q && !run) active_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + HW'(1);
      end
    end
  end

  assign sclk       = pol_q ^ phase_q;
  assign shift_stb  = shift_q;
  assign sample_stb = sample_q;

  p_disable_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (sclk == $past(cpol)) && !shift_stb && !sample_stb);

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_stb && sample_stb));

  p_edge_has_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && (sclk != $past(sclk))) |-> (shift_stb || sample_stb));

  p_strobe_is_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_stb || sample_stb) |-> (sclk != $past(sclk)));

  p_cfg_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> ($stable(pol_q) && $stable(pha_q)));

  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |=> (cnt_q == '0));

endmodule

// File: tb/spi_sclk_divider_bench.sv
module spi_sclk_divider_bench;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, lin_mode = 1'b0;
  logic [7:0] div_val = 8'd0;
  logic cpol = 1'b0, cpha = 1'b0, run = 1'b0;
  logic sclk, shift_stb, sample_stb;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  spi_sclk_divider u_spi_sclk_divider (
    .clk(clk), .rst_n(rst_n), .en(en), .lin_mode(lin_mode), .div_val(div_val),
    .cpol(cpol), .cpha(cpha), .run(run), .sclk(sclk),
    .shift_stb(shift_stb), .sample_stb(sample_stb));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts posedges until sclk changes; sampled at negedges
  task automatic edge_wait(output int k, output logic sh, output logic sa);
    logic prev;
    prev = sclk;
    k = 0;
    do begin
      @(posedge clk); @(negedge clk); k++;
    end while (sclk == prev && k < 70000);
    sh = shift_stb;
    sa = sample_stb;
  endtask

  task automatic setup(input logic lm, input int n, input logic p, input logic h);
    @(negedge clk);
    en = 1'b0; run = 1'b0; lin_mode = lm; div_val = 8'(n); cpol = p; cpha = h;
    @(negedge clk); @(negedge clk);
    en = 1'b1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(sclk == 1'b0 && !shift_stb && !sample_stb, "R7 reset idle", int'(sclk), 0);
  endtask

  task automatic t_rate(input logic lm, input int n, input int h, input string req);
    int k; logic sh, sa;
    setup(lm, n, 1'b0, 1'b0);
    run = 1'b1;
    check(sclk == 1'b0, "R4 idle at cpol", int'(sclk), 0);
    edge_wait(k, sh, sa);
    check(k == h + 1, {req, " first edge (R4)"}, k, h + 1);
    edge_wait(k, sh, sa);
    check(k == h, {req, " half-period"}, k, h);
    edge_wait(k, sh, sa);
    check(k == h, {req, " next half-period"}, k, h);
  endtask

  task automatic t_phase(input logic p, input logic h);
    int k; logic sh, sa;
    setup(1'b1, 2, p, h);
    run = 1'b1;
    check(sclk == p, "R4 idle level", int'(sclk), int'(p));
    edge_wait(k, sh, sa);
    check(sa == !h && sh == h, "R5 leading edge strobes", {sh, sa}, {h, !h});
    @(posedge clk); @(negedge clk);
    check(!sh || !shift_stb, "R5 strobe one cycle", int'(shift_stb), 0);
    check(!sample_stb && !shift_stb, "R5 strobes drop", {shift_stb, sample_stb}, 0);
    edge_wait(k, sh, sa);
    check(sa == h && sh == !h, "R5 trailing edge strobes", {sh, sa}, {!h, h});
  endtask

  task automatic t_ignore;
    int k; logic sh, sa;
    setup(1'b1, 1, 1'b1, 1'b0);
    cpol = 1'b0; cpha = 1'b1;
    @(negedge clk);
    check(sclk == 1'b1, "R6 cpol change ignored", int'(sclk), 1);
    run = 1'b1;
    edge_wait(k, sh, sa);
    check(sclk == 1'b0 && sa && !sh, "R6 cpha change ignored", {sh, sa}, 1);
  endtask

  task automatic t_disable;
    int k; logic sh, sa;
    setup(1'b1, 3, 1'b0, 1'b0);
    run = 1'b1;
    edge_wait(k, sh, sa);
    check(sclk == 1'b1, "R7 clock active before disable", int'(sclk), 1);
    en = 1'b0;
    @(negedge clk);
    check(sclk == 1'b0 && !shift_stb && !sample_stb, "R7 forced idle", int'(sclk), 0);
    en = 1'b1;
    edge_wait(k, sh, sa);
    check(k == 5, "R7 counter cleared", k, 5);
  endtask

  task automatic t_stop;
    int k, changes; logic sh, sa, prev;
    setup(1'b1, 1, 1'b0, 1'b0);
    run = 1'b1;
    edge_wait(k, sh, sa);
    run = 1'b0;
    changes = 0;
    prev = sclk;
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); @(negedge clk);
      if (sclk != prev) changes++;
      prev = sclk;
    end
    check(changes == 1, "R8 single trailing edge", changes, 1);
    check(sclk == 1'b0, "R8 stops at idle", int'(sclk), 0);
  endtask

  task automatic t_excl;
    int bad = 0;
    setup(1'b1, 0, 1'b0, 1'b1);
    run = 1'b1;
    for (int i = 0; i < 20; i++) begin
      logic prev;
      prev = sclk;
      @(posedge clk); @(negedge clk);
      if ((shift_stb && sample_stb) || ((sclk != prev) != (shift_stb || sample_stb))) bad++;
    end
    check(bad == 0, "R9 strobe/edge pairing", bad, 0);
  endtask

  initial begin
    #4000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rate(1'b0, 0, 1, "R1 N=0");
    t_rate(1'b0, 3, 8, "R1 N=3");
    t_rate(1'b1, 0, 1, "R3 N=0");
    t_rate(1'b1, 5, 6, "R3 N=5");
    t_rate(1'b1, 255, 256, "R3 N=255");
    begin
      int k; logic sh, sa;
      setup(1'b0, 15, 1'b0, 1'b0); run = 1'b1;
      edge_wait(k, sh, sa);
      check(k == 32769, "R1 N=15 first edge", k, 32769);
      setup(1'b0, 20, 1'b0, 1'b0); run = 1'b1;
      edge_wait(k, sh, sa);
      check(k == 32769, "R2 clamp N=20", k, 32769);
    end
    t_phase(1'b0, 1'b0);
    t_phase(1'b1, 1'b1);
    t_ignore();
    t_disable();
    t_stop();
    t_excl();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule